// File: doc/BRIEF.md
# Banked Byte Store with Access Window

This block is a byte-wide data store of 4096 locations, seen by the requester through a 4-bit bank pointer. Most requests carry only an 8-bit offset. The block combines that offset with either the bank pointer or a fixed "access window" to form the 12-bit physical address. The window joins the lowest 96 bytes of bank 0 with the highest 160 bytes of bank 15, and it is reachable whatever the pointer holds. A third request kind names two full 12-bit addresses. It copies one byte from the first to the second without looking at the bank pointer.

A bank pointer load port writes the pointer from a literal, and the pointer is visible as an 8-bit value. The `BANK_MASK` parameter chooses which banks have storage behind them. A bank without storage drops writes and returns zero on reads, but every request still completes normally. Requests use a valid/ready handshake: a request is taken on a rising edge where both `req_valid` and `req_ready` are high. Back-pressure comes only from the copy, which holds `req_ready` low for the one cycle in which it writes. The response side has no ready. `rsp_valid` is a single-cycle pulse, and the requester must take it on that cycle.

Top module: `banked_ram`

## Requirements
- R1: With `req_banked`=1 and `req_direct`=0, the physical address is the bank pointer as bits 11:8 and `req_offset` as bits 7:0.
- R2: A cycle with `bank_load`=1 loads `bank_load_val[3:0]` into the bank pointer. `bank_q` shows the pointer in bits 3:0, and bits 7:4 of `bank_q` are always 0. Reset clears the pointer to 0.
- R3: Without `bank_load`, the bank pointer keeps its value across any number of requests.
- R4: With `req_banked`=0 and `req_direct`=0, the bank pointer is ignored. Offsets 00h-5Fh address 000h-05Fh, and offsets 60h-FFh address F60h-FFFh.
- R5: A request with `req_direct`=1 reads `req_src` and writes that byte to `req_dst`. In the cycle after acceptance, `req_ready` is 0 and `rsp_valid` is 0. In the next cycle, `rsp_valid` is 1 and `rsp_rdata` carries the copied byte.
- R6: A write whose physical address lies in a bank whose `BANK_MASK` bit is 0 changes no stored byte.
- R7: A read from a bank whose `BANK_MASK` bit is 0 returns 00h. A copy from such a bank writes 00h to its destination.
- R8: Every accepted request yields exactly one `rsp_valid` pulse, including requests that touch unimplemented banks. A write's response carries `rsp_rdata`=00h.
- R9: An offset read or write is accepted and answered in the cycle after the accepting edge. Read data comes from the location addressed at acceptance.
- R10: `req_ready` is 1 in every cycle except the second cycle of a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_load | input | 1 | Load the bank pointer this cycle |
| bank_load_val | input | 8 | Literal for the pointer; only bits 3:0 are kept |
| bank_q | output | 8 | Current bank pointer, upper nibble zero |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_direct | input | 1 | 1: full-address copy from req_src to req_dst |
| req_banked | input | 1 | 1: use bank pointer, 0: use access window |
| req_write | input | 1 | 1: write req_wdata, 0: read (offset modes) |
| req_offset | input | 8 | Offset within the selected bank or window |
| req_wdata | input | 8 | Write data |
| req_src | input | 12 | Copy source address |
| req_dst | input | 12 | Copy destination address |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read or copied byte; 00h for writes |

## Verification
The assertions assume that the requester never presents a bank load in the same cycle as a request that depends on the new pointer. They also assume the requester keeps `req_valid` low while it waits on an outstanding response. The bench meets both assumptions by running strictly one operation at a time. It separates each pointer load from the following request by at least one cycle. A near-exhaustive sweep then writes and reads every offset of every bank, with a bank mask that leaves several banks empty. This is followed by a full access-window sweep under an unimplemented bank pointer, and by copies with implemented and empty banks on either end.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;
  localparam int unsigned BANK_W = 4;
  localparam int unsigned OFF_W  = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = BANK_W + OFF_W;
  localparam int unsigned NBANK  = 1 << BANK_W;
  localparam int unsigned WIN_SPLIT = 96;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_COPY = 1'b1
  } seq_state_t;
endpackage

// File: rtl/bank_select_reg.sv
module bank_select_reg #(
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] load_val,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank <= '0;
    else if (load) bank <= load_val;
  end

  // R2: a load takes effect on the next cycle
  p_load_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bank == $past(load_val));
  // R3: pointer holds when not loaded
  p_bank_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank));
endmodule

// File: rtl/addr_translate.sv
module addr_translate #(
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned WIN_SPLIT = 96
) (
  input  logic [BANK_W-1:0]       bank,
  input  logic                    banked,
  input  logic [OFF_W-1:0]        offset,
  output logic [BANK_W+OFF_W-1:0] addr
);
  localparam logic [BANK_W-1:0] WIN_LO_BANK = '0;
  localparam logic [BANK_W-1:0] WIN_HI_BANK = '1;
  localparam logic [OFF_W-1:0]  SPLIT_OFF   = OFF_W'(WIN_SPLIT);

  logic [BANK_W-1:0] win_bank;

  always_comb begin
    win_bank = (offset < SPLIT_OFF) ? WIN_LO_BANK : WIN_HI_BANK;
    addr     = {(banked ? bank : win_bank), offset};
  end
endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [(1<<BANK_W)-1:0] BANK_MASK = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [BANK_W+OFF_W-1:0] waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    re,
  input  logic [BANK_W+OFF_W-1:0] raddr,
  output logic [DATA_W-1:0]       rdata
);
  localparam int unsigned NBANK = 1 << BANK_W;
  localparam int unsigned DEPTH = 1 << OFF_W;
  localparam int unsigned AW    = BANK_W + OFF_W;

  logic [DATA_W-1:0] bank_rd [NBANK];
  logic [BANK_W-1:0] rd_bank_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (BANK_MASK[b]) begin : g_impl
      logic [DATA_W-1:0] mem [DEPTH];
      logic hit_w, hit_r;
      assign hit_w = we && (waddr[AW-1:OFF_W] == BANK_W'(b));
      assign hit_r = re && (raddr[AW-1:OFF_W] == BANK_W'(b));
      always_ff @(posedge clk) begin
        if (hit_w) mem[waddr[OFF_W-1:0]] <= wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bank_rd[b] <= '0;
        else if (hit_r) bank_rd[b] <= mem[raddr[OFF_W-1:0]];
      end
    end else begin : g_empty
      assign bank_rd[b] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_bank_q <= '0;
    else if (re) rd_bank_q <= raddr[AW-1:OFF_W];
  end

  assign rdata = bank_rd[rd_bank_q];

  // R7: reads of empty banks return zero
  p_empty_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (re && !BANK_MASK[raddr[AW-1:OFF_W]]) |=> rdata == '0);
  // R9: read data holds while no read is issued
  p_rdata_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!re && !(we && waddr == raddr)) |=> $stable(rdata));
endmodule

// File: rtl/banked_ram.sv
module banked_ram
  import banked_ram_pkg::*;
#(
  parameter logic [15:0] BANK_MASK = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_load,
  input  logic [DATA_W-1:0] bank_load_val,
  output logic [DATA_W-1:0] bank_q,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_direct,
  input  logic              req_banked,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  seq_state_t        state;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] xaddr, dst_q;
  logic              accept, is_copy;
  logic              st_we, st_re;
  logic [ADDR_W-1:0] st_waddr, st_raddr;
  logic [DATA_W-1:0] st_wdata, st_rdata;
  logic              rsp_valid_q, rsp_is_rd_q;
  logic [DATA_W-BANK_W-1:0] unused_load_hi;

  assign unused_load_hi = bank_load_val[DATA_W-1:BANK_W];

  bank_select_reg #(.BANK_W(BANK_W)) u_bsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bank_load),
    .load_val (bank_load_val[BANK_W-1:0]),
    .bank     (bank)
  );

  addr_translate #(.BANK_W(BANK_W), .OFF_W(OFF_W), .WIN_SPLIT(WIN_SPLIT)) u_xlate (
    .bank   (bank),
    .banked (req_banked),
    .offset (req_offset),
    .addr   (xaddr)
  );

  assign bank_q    = {{(DATA_W-BANK_W){1'b0}}, bank};
  assign is_copy   = (state == SEQ_COPY);
  assign req_ready = !is_copy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_re    = accept && (req_direct || !req_write);
    st_raddr = req_direct ? req_src : xaddr;
    st_we    = is_copy || (accept && !req_direct && req_write);
    st_waddr = is_copy ? dst_q : xaddr;
    st_wdata = is_copy ? st_rdata : req_wdata;
  end

  bank_store #(
    .BANK_W(BANK_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .BANK_MASK(BANK_MASK)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .re    (st_re),
    .raddr (st_raddr),
    .rdata (st_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_IDLE;
      dst_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_is_rd_q <= 1'b0;
    end else begin
      state       <= (accept && req_direct) ? SEQ_COPY : SEQ_IDLE;
      if (accept && req_direct) dst_q <= req_dst;
      rsp_valid_q <= (accept && !req_direct) || is_copy;
      rsp_is_rd_q <= (accept && !req_direct && !req_write) || is_copy;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_is_rd_q ? st_rdata : '0;

  // R5: copy stalls one cycle, then responds
  p_copy_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_direct) |=> (!req_ready && !rsp_valid) ##1 rsp_valid);
  // R9: offset accesses answer on the next cycle
  p_offset_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_direct) |=> rsp_valid);
  // R10: offset accesses never stall the next request
  p_ready_after_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_direct) |=> req_ready);
  // R8: write responses carry zero
  p_write_rsp_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_direct && req_write) |=> rsp_rdata == '0);
endmodule

// File: tb/banked_ram_test.sv
`timescale 1ns/1ps
module banked_ram_test;
  localparam logic [15:0] MASK = 16'h80F7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_load = 1'b0;
  logic [7:0]  bank_load_val = '0;
  logic [7:0]  bank_q;
  logic        req_valid = 1'b0, req_ready;
  logic        req_direct = 1'b0, req_banked = 1'b0, req_write = 1'b0;
  logic [7:0]  req_offset = '0, req_wdata = '0;
  logic [11:0] req_src = '0, req_dst = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [4096];

  always #2 clk = ~clk;

  banked_ram #(.BANK_MASK(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .bank_load(bank_load), .bank_load_val(bank_load_val),
    .bank_q(bank_q), .req_valid(req_valid), .req_ready(req_ready),
    .req_direct(req_direct), .req_banked(req_banked), .req_write(req_write),
    .req_offset(req_offset), .req_wdata(req_wdata), .req_src(req_src),
    .req_dst(req_dst), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic bit impl(input logic [11:0] a);
    return MASK[a[11:8]];
  endfunction

  function automatic logic [7:0] pat(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_bank(input logic [7:0] v);
    @(negedge clk);
    bank_load = 1'b1; bank_load_val = v;
    @(posedge clk);
    @(negedge clk);
    bank_load = 1'b0;
  endtask

  // offset access; returns response data sampled one cycle after acceptance
  task automatic offset_op(input bit banked, input bit wr, input logic [7:0] off,
                           input logic [7:0] wd, output logic [7:0] rd, output bit vld);
    @(negedge clk);
    req_valid = 1'b1; req_direct = 1'b0; req_banked = banked;
    req_write = wr; req_offset = off; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; vld = rsp_valid;
  endtask

  task automatic read_abs(input logic [11:0] a, input string tag);
    logic [7:0] rd; bit v;
    load_bank({4'h0, a[11:8]});
    offset_op(1'b1, 1'b0, a[7:0], 8'h00, rd, v);
    chk(tag, rd, impl(a) ? model[a] : 8'h00);
  endtask

  task automatic copy_op(input logic [11:0] s, input logic [11:0] d);
    logic [7:0] expv;
    expv = impl(s) ? model[s] : 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_direct = 1'b1; req_src = s; req_dst = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_direct = 1'b0;
    chk("R5 ready low in copy write cycle", req_ready, 0);
    chk("R5 no response in copy write cycle", rsp_valid, 0);
    @(negedge clk);
    chk("R5 copy response", rsp_valid, 1);
    chk("R5 copied byte", rsp_rdata, expv);
    chk("R10 ready back after copy", req_ready, 1);
    if (impl(d)) model[d] = expv;
    read_abs(d, "R5/R6/R7 copy destination");
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd; bit v;
    repeat (3) @(negedge clk);
    chk("R2 reset pointer", bank_q, 0);
    chk("R8 no response at reset", rsp_valid, 0);
    chk("R10 ready at reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: every literal, upper nibble dropped
    for (int i = 0; i < 256; i++) begin
      load_bank(8'(i));
      chk("R2 pointer load", bank_q, i & 15);
    end

    // fill all banks through the banked mode
    for (int b = 0; b < 16; b++) begin
      load_bank(8'(b | 8'hA0));
      for (int o = 0; o < 256; o++) begin
        logic [11:0] a;
        a = 12'(b * 256 + o);
        offset_op(1'b1, 1'b1, 8'(o), pat(a), rd, v);
        chk("R8 write response valid", v, 1);
        chk("R8 write response data", rd, 0);
        if (impl(a)) model[a] = pat(a);
      end
      chk("R3 pointer held across writes", bank_q, b);
    end

    // R1/R6/R7: read back every location
    for (int b = 0; b < 16; b++) begin
      load_bank(8'(b));
      for (int o = 0; o < 256; o++) begin
        logic [11:0] a;
        a = 12'(b * 256 + o);
        offset_op(1'b1, 1'b0, 8'(o), 8'h00, rd, v);
        chk("R9 read response valid", v, 1);
        if (impl(a)) chk("R1 banked read / R6 untouched", rd, pat(a));
        else         chk("R7 empty bank reads zero", rd, 0);
      end
    end

    // R4: window sweep with pointer on an empty bank
    load_bank(8'h09);
    for (int o = 0; o < 256; o++) begin
      logic [11:0] a;
      a = (o < 96) ? 12'(o) : 12'(12'hF00 + o);
      offset_op(1'b0, 1'b0, 8'(o), 8'h00, rd, v);
      chk("R4 window read", rd, model[a]);
    end
    offset_op(1'b0, 1'b1, 8'h5F, 8'hC3, rd, v);  model[12'h05F] = 8'hC3;
    offset_op(1'b0, 1'b1, 8'h60, 8'h3C, rd, v);  model[12'hF60] = 8'h3C;
    chk("R3 pointer held across window ops", bank_q, 9);
    read_abs(12'h05F, "R4 window low edge lands in bank 0");
    read_abs(12'hF60, "R4 window high edge lands in bank 15");
    read_abs(12'h95F, "R6 empty bank still empty");

    // R5: copies
    load_bank(8'h03);
    copy_op(12'h123, 12'h456);
    copy_op(12'h305, 12'h010);
    copy_op(12'h0AB, 12'h9AB);
    copy_op(12'hF61, 12'h7FF);
    copy_op(12'h7FF, 12'h000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule